// File: doc/BRIEF.md
# Multi-Lane Selectable-Ratio Deserializer

This block gathers bits from a group of single-bit serial lanes that all run on one fast bit clock. It packs them into parallel words, one per lane. Every lane shares a single bit counter, so the words of all lanes close on the same clock cycle. A downstream consumer therefore sees one wide word made of all lane slices, for example sixteen lanes of eight bits forming 128 bits. The block has no second clock domain. The consumer uses the word-rate enable and the valid strobe to pick the words out of the fast-clock stream.

The packing ratio is selected at run time. The choices are eight, seven or four bits per word, plus a pass-through mode in which every serial bit forms a word of its own. A new ratio is picked up only at the first bit of a word, so a word that has already started is never cut short or stretched. A sync input restarts word framing for every lane at once. The bit sampled in the sync cycle becomes the first bit of a fresh word, and any partly gathered word is dropped.

Top module: `deser_array`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `word_valid` is 0 and `par_word` is all zeros.
- R2: With `ratio_sel` = 0 (eight bits), bits enter most-significant first. The first bit of a word lands in slice bit 7 and the last bit lands in slice bit 0.
- R3: Words close once every N bit-clock cycles, where N is 8, 7, 4 or 1 for `ratio_sel` = 0, 1, 2 or 3. `word_valid` is 0 in every other cycle.
- R4: With `ratio_sel` = 1 (seven bits), the word fills slice bits 6..0 most-significant first. Bit 7 of each slice is 0.
- R5: With `ratio_sel` = 2 (four bits), the word fills slice bits 3..0 most-significant first. Slice bits 7..4 are 0.
- R6: With `ratio_sel` = 3 (pass-through), `word_valid` is 1 on every cycle. Each slice carries the last sampled bit in bit 0 and zeros above it.
- R7: Lane i always occupies `par_word[8*i+7 : 8*i]`. All lanes close their words in the same cycle.
- R8: A cycle with `sync_pulse` = 1 makes the bit sampled in that cycle the first bit of a new word. Any word in progress is discarded without a `word_valid`.
- R9: `ratio_sel` is sampled only during the first bit of a word. A change made later in the word takes effect from the next word onward.
- R10: `word_ce` is 1 in exactly the cycles whose sampled bit is the last bit of a word. `word_valid` is 1 in the cycle after, and it comes with the new `par_word`. `par_word` holds its value between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock; one serial bit per lane per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | NUM_LANES | One serial bit per lane |
| ratio_sel | input | 2 | Bits per word: 0 = eight, 1 = seven, 2 = four, 3 = pass-through |
| sync_pulse | input | 1 | Restarts word framing on all lanes at the current bit |
| par_word | output | NUM_LANES*WORD_W | Concatenated parallel words, lane 0 in the low slice |
| word_valid | output | 1 | One-cycle strobe marking a fresh `par_word` |
| word_ce | output | 1 | Word-rate enable, high during the last bit of each word |

## Verification
The sync restart and the ratio sampling both act on the first bit of a word. A sync pulse also forces that first-bit condition in the middle of a word. The bench provokes this by sending five bits of an eight-bit word and then pulsing sync while it presents the first bit of a new word. It judges the result by the absence of any strobe before eight further bits, followed by an exact slice match for all lanes. A second case changes `ratio_sel` part way through a word in both directions (eight to four, four to eight). The word closes at the length chosen at its first bit, and the following word uses the new length.

// File: rtl/deser_pkg.sv
package deser_pkg;

   // Ratio select encoding used on the top-level port
   typedef enum logic [1:0] {
      RATIO_X8 = 2'd0,
      RATIO_X7 = 2'd1,
      RATIO_X4 = 2'd2,
      RATIO_X1 = 2'd3
   } ratio_e;

   localparam int MAX_LANES = 16;
   localparam int MIN_WORD_W = 8;

   // Number of serial bits forming one word for a given ratio
   function automatic int ratio_len(ratio_e r);
      case (r)
         RATIO_X8: return 8;
         RATIO_X7: return 7;
         RATIO_X4: return 4;
         default:  return 1;
      endcase
   endfunction

endpackage

// File: rtl/deser_ctrl.sv
module deser_ctrl
   import deser_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ratio_e            ratio_sel,
   input  logic              sync_pulse,
   output logic              last_bit,
   output ratio_e            eff_ratio,
   output logic [WORD_W-1:0] word_mask
);

   localparam int CNT_W = $clog2(WORD_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] eff_cnt;
   logic [CNT_W-1:0] len_m1;
   ratio_e           ratio_q;
   int               len_i;
   logic             first_bit;

   // A sync pulse forces the current bit to be the first of a word
   assign eff_cnt   = sync_pulse ? '0 : cnt_q;
   assign first_bit = (eff_cnt == '0);
   assign eff_ratio = first_bit ? ratio_sel : ratio_q;
   assign len_i     = ratio_len(eff_ratio);
   assign len_m1    = CNT_W'(len_i - 1);
   assign last_bit  = (eff_cnt == len_m1);

   always_comb begin
      word_mask = '0;
      for (int i = 0; i < WORD_W; i++) begin
         word_mask[i] = (i < len_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= RATIO_X8;
      end else begin
         cnt_q <= last_bit ? '0 : eff_cnt + 1'b1;
         if (first_bit) begin
            ratio_q <= ratio_sel;
         end
      end
   end

endmodule

// File: rtl/deser_lane.sv
module deser_lane #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   input  logic              capture,
   input  logic [WORD_W-1:0] word_mask,
   output logic [WORD_W-1:0] word_out
);

   logic [WORD_W-2:0] sh_q;
   logic [WORD_W-1:0] full;

   // Newest bit at position 0, so the oldest bit of a word is the highest
   assign full = {sh_q, ser_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         word_out <= '0;
      end else begin
         sh_q <= full[WORD_W-2:0];
         if (capture) begin
            word_out <= full & word_mask;
         end
      end
   end

endmodule

// File: rtl/deser_array.sv
module deser_array
   import deser_pkg::*;
#(
   parameter int NUM_LANES = 16,
   parameter int WORD_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES-1:0]        ser_in,
   input  logic [1:0]                  ratio_sel,
   input  logic                        sync_pulse,
   output logic [NUM_LANES*WORD_W-1:0] par_word,
   output logic                        word_valid,
   output logic                        word_ce
);

   localparam int BUS_W = NUM_LANES * WORD_W;

   if (NUM_LANES < 1 || NUM_LANES > MAX_LANES) begin : g_bad_lanes
      $error("deser_array: NUM_LANES must be within 1..%0d", MAX_LANES);
   end
   if (WORD_W < MIN_WORD_W) begin : g_bad_width
      $error("deser_array: WORD_W must be at least %0d", MIN_WORD_W);
   end

   logic              last_bit;
   ratio_e            eff_ratio;
   logic [WORD_W-1:0] word_mask;
   logic              valid_q;

   deser_ctrl #(.WORD_W(WORD_W)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ratio_sel (ratio_e'(ratio_sel)),
      .sync_pulse(sync_pulse),
      .last_bit  (last_bit),
      .eff_ratio (eff_ratio),
      .word_mask (word_mask)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      deser_lane #(.WORD_W(WORD_W)) lane_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .ser_bit  (ser_in[g]),
         .capture  (last_bit),
         .word_mask(word_mask),
         .word_out (par_word[g*WORD_W +: WORD_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= last_bit;
      end
   end

   assign word_valid = valid_q;
   assign word_ce    = last_bit;

endmodule

// File: rtl/deser_array_chk.sv
module deser_array_chk #(
   parameter int NUM_LANES = 16,
   parameter int WORD_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        sync_pulse,
   input logic                        word_ce,
   input logic                        word_valid,
   input logic [NUM_LANES*WORD_W-1:0] par_word,
   input logic [1:0]                  eff_ratio
);

   logic hi7_any;
   logic hi4_any;

   always_comb begin
      hi7_any = 1'b0;
      hi4_any = 1'b0;
      for (int l = 0; l < NUM_LANES; l++) begin
         for (int b = 4; b < WORD_W; b++) begin
            hi4_any = hi4_any | par_word[l*WORD_W + b];
            if (b >= 7) begin
               hi7_any = hi7_any | par_word[l*WORD_W + b];
            end
         end
      end
   end

   // R10
   ce_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_ce |=> word_valid);

   // R10
   quiet_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_ce |=> !word_valid);

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_ce |=> $stable(par_word));

   // R4
   x7_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_ce && eff_ratio == 2'd1) |=> !hi7_any);

   // R5
   x4_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_ce && eff_ratio == 2'd2) |=> !hi4_any);

   // R8
   sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pulse && eff_ratio != 2'd3) |-> !word_ce);

endmodule

bind deser_array deser_array_chk #(
   .NUM_LANES(NUM_LANES),
   .WORD_W   (WORD_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_pulse(sync_pulse),
   .word_ce   (word_ce),
   .word_valid(word_valid),
   .par_word  (par_word),
   .eff_ratio (eff_ratio)
);

// File: tb/deser_array_tb_top.sv
module deser_array_tb_top;

   localparam int L = 16;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sync_pulse = 1'b0;
   logic [L-1:0]   ser_in = '0;
   logic [1:0]     ratio_sel = 2'd0;
   logic [L*W-1:0] par_word;
   logic           word_valid;
   logic           word_ce;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   deser_array #(.NUM_LANES(L), .WORD_W(W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_in    (ser_in),
      .ratio_sel (ratio_sel),
      .sync_pulse(sync_pulse),
      .par_word  (par_word),
      .word_valid(word_valid),
      .word_ce   (word_ce)
   );

   task automatic check(string tag, string what, logic [L*W-1:0] act, logic [L*W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int len_of(logic [1:0] s);
      case (s)
         2'd0: return 8;
         2'd1: return 7;
         2'd2: return 4;
         default: return 1;
      endcase
   endfunction

   function automatic logic [W-1:0] lane_val(int seed, int l);
      return W'(seed * 53 + l * 71 + 13);
   endfunction

   // Sends one word on all lanes, checking strobe, enable and the result
   task automatic send_word(string tag, logic [1:0] sel, int seed, bit sync_first,
                            int chg_at, logic [1:0] chg_sel);
      int             len;
      logic [W-1:0]   msk;
      logic [L*W-1:0] exp;
      logic [W-1:0]   v;
      len = len_of(sel);
      msk = W'((1 << len) - 1);
      exp = '0;
      for (int l = 0; l < L; l++) begin
         exp[l*W +: W] = lane_val(seed, l) & msk;
      end
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         ratio_sel  = (chg_at >= 0 && i >= chg_at) ? chg_sel : sel;
         sync_pulse = sync_first && (i == 0);
         for (int l = 0; l < L; l++) begin
            v = lane_val(seed, l);
            ser_in[l] = v[len-1-i];
         end
         #1;
         // R10: enable only on the last bit
         check("R10", "word_ce", {{(L*W-1){1'b0}}, word_ce}, {{(L*W-1){1'b0}}, (i == len-1)});
         @(posedge clk);
         #1;
         check(tag, "word_valid", {{(L*W-1){1'b0}}, word_valid}, {{(L*W-1){1'b0}}, (i == len-1)});
         if (i == len-1) begin
            check(tag, "par_word", par_word, exp);
         end
      end
      sync_pulse = 1'b0;
   endtask

   // Partial eight-bit word that a later sync abandons
   task automatic send_junk(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ratio_sel  = 2'd0;
         sync_pulse = 1'b0;
         ser_in     = L'(16'hA5C3 ^ (i * 16'h1111));
         @(posedge clk);
         #1;
         // R8: no strobe for the partial word
         check("R8", "word_valid", {{(L*W-1){1'b0}}, word_valid}, '0);
      end
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1
      check("R1", "word_valid", {{(L*W-1){1'b0}}, word_valid}, '0);
      check("R1", "par_word", par_word, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", "word_valid after release", {{(L*W-1){1'b0}}, word_valid}, '0);
   endtask

   task automatic test_x8();
      send_word("R2", 2'd0, 1, 1'b1, -1, 2'd0);
      send_word("R7", 2'd0, 2, 1'b0, -1, 2'd0);
      send_word("R3", 2'd0, 3, 1'b0, -1, 2'd0);
   endtask

   task automatic test_x7();
      send_word("R4", 2'd1, 4, 1'b0, -1, 2'd0);
      send_word("R4", 2'd1, 5, 1'b0, -1, 2'd0);
   endtask

   task automatic test_x4();
      send_word("R5", 2'd2, 6, 1'b0, -1, 2'd0);
      send_word("R5", 2'd2, 7, 1'b0, -1, 2'd0);
   endtask

   task automatic test_bypass();
      for (int k = 0; k < 6; k++) begin
         send_word("R6", 2'd3, 8 + k, 1'b0, -1, 2'd0);
      end
   endtask

   task automatic test_ratio_change();
      // R9: change eight to four mid-word, then four to eight mid-word
      send_word("R9", 2'd0, 20, 1'b0, 3, 2'd2);
      send_word("R9", 2'd2, 21, 1'b0, 1, 2'd0);
      send_word("R9", 2'd0, 22, 1'b0, -1, 2'd0);
   endtask

   task automatic test_sync();
      send_junk(5);
      send_word("R8", 2'd0, 23, 1'b1, -1, 2'd0);
      send_word("R8", 2'd2, 24, 1'b0, -1, 2'd0);
   endtask

   initial begin
      test_reset();
      test_x8();
      test_x7();
      test_x4();
      test_bypass();
      test_ratio_change();
      test_sync();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule